// File: doc/BRIEF.md
# Bi-Mode Branch Direction Predictor

This block predicts whether a conditional branch at a given fetch address is taken. It keeps three tables of 2-bit saturating counters. A choice table, indexed by the branch address alone, decides which of two direction tables gives the answer. One direction table starts biased toward taken and the other toward not-taken. Both are indexed by the branch address XOR the global outcome history. Branches with a strong bias in one direction tend to train only the table that matches that bias, so branches with opposite habits alias less.

The fetch side presents an address each cycle and reads `pred_taken_o` in the same cycle. It saves `ghr_o` with the branch. When the branch resolves, the pipeline returns the address, the real outcome and that saved history. On that update the block trains the tables and shifts the outcome into its history register. Target prediction is not part of this block.

Top module: `bimode_pred`

## Requirements
- R1: After reset the history register is zero. Every choice counter and every not-taken-biased counter holds 01, and every taken-biased counter holds 10. The prediction is therefore not-taken for every address. Counter codes: 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken.
- R2: The prediction is the MSB of the taken-biased table entry when the choice counter MSB is 1. Otherwise it is the MSB of the not-taken-biased table entry. It is combinational from `fetch_pc_i` and the current history.
- R3: The choice index folds the address onto CH_IDX_W bits, with address bit j XORed into index bit j mod CH_IDX_W. The history does not affect it.
- R4: The direction index is the address folded onto DIR_IDX_W bits in the same way, XORed with the history folded onto DIR_IDX_W bits. History bit j goes to index bit j mod DIR_IDX_W.
- R5: On an update only the direction table chosen by the choice counter at the update index is trained with the outcome. The other table is unchanged.
- R6: On an update the choice counter moves toward the outcome. The exception is when its choice disagreed with the outcome while the chosen direction counter predicted the outcome correctly. In that case it stays unchanged.
- R7: Counters saturate: a taken at 11 stays 11 and a not-taken at 00 stays 00.
- R8: On each update the history shifts left by one and the outcome enters bit 0, with 1 meaning taken. Without an update it holds.
- R9: Update indices use the saved history `upd_ghr_i`, not the current history register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_pc_i | input | PC_W | Address of the branch being fetched |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| upd_valid_i | input | 1 | A resolved branch is presented this cycle |
| upd_pc_i | input | PC_W | Address of the resolved branch |
| upd_taken_i | input | 1 | Actual outcome, 1 = taken |
| upd_ghr_i | input | GHR_W | History saved when the branch was predicted |
| ghr_o | output | GHR_W | Current global history |

## Verification
The hardest case to reach is the choice counter being left alone: it needs an entry whose choice disagrees with the outcome while the chosen direction counter is already right. The bench trains one direction entry through one address. It then updates a second address that has a fresh choice counter, using a saved history picked so that both land on the same direction entry. Saturation is reached by repeated updates with a fixed saved history that equals the history the register will hold afterwards, so the trained entry can be read back through the fetch port. A long mixed stream, sometimes with stale saved histories, is compared with a model built from the requirements.

// File: rtl/bimode_pkg.sv
package bimode_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_WEAK_NT = 2'b01;
  localparam ctr_t CTR_WEAK_T  = 2'b10;

  function automatic ctr_t ctr_next(ctr_t c, logic taken);
    if (taken) return (c == 2'b11) ? c : c + 2'b01;
    else       return (c == 2'b00) ? c : c - 2'b01;
  endfunction
endpackage

// File: rtl/bimode_ctr_table.sv
module bimode_ctr_table
  import bimode_pkg::*;
#(
  parameter int   IDX_W   = 8,
  parameter ctr_t RST_VAL = CTR_WEAK_NT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] fetch_idx_i,
  output logic             fetch_pred_o,
  input  logic [IDX_W-1:0] upd_idx_i,
  output logic             upd_pred_o,
  input  logic             upd_en_i,
  input  logic             upd_taken_i
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_t mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= RST_VAL;
    end else if (upd_en_i) begin
      mem_q[upd_idx_i] <= ctr_next(mem_q[upd_idx_i], upd_taken_i);
    end
  end

  assign fetch_pred_o = mem_q[fetch_idx_i][1];
  assign upd_pred_o   = mem_q[upd_idx_i][1];
endmodule

// File: rtl/bimode_ghr.sv
module bimode_ghr #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] ghr_o
);
  logic [W-1:0] ghr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ghr_q <= '0;
    else if (shift_i) ghr_q <= {ghr_q[W-2:0], bit_i};
  end

  assign ghr_o = ghr_q;
endmodule

// File: rtl/bimode_pred.sv
module bimode_pred
  import bimode_pkg::*;
#(
  parameter int PC_W      = 12,
  parameter int CH_IDX_W  = 8,
  parameter int DIR_IDX_W = 8,
  parameter int GHR_W     = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PC_W-1:0]  fetch_pc_i,
  output logic             pred_taken_o,
  input  logic             upd_valid_i,
  input  logic [PC_W-1:0]  upd_pc_i,
  input  logic             upd_taken_i,
  input  logic [GHR_W-1:0] upd_ghr_i,
  output logic [GHR_W-1:0] ghr_o
);
  logic [GHR_W-1:0]     ghr_q;
  logic [CH_IDX_W-1:0]  f_ch_idx, u_ch_idx;
  logic [DIR_IDX_W-1:0] f_dpc, u_dpc, f_hist, u_hist;
  logic [DIR_IDX_W-1:0] f_dir_idx, u_dir_idx;

  // XOR-fold address and history onto index widths
  always_comb begin
    f_ch_idx = '0;
    u_ch_idx = '0;
    f_dpc    = '0;
    u_dpc    = '0;
    f_hist   = '0;
    u_hist   = '0;
    for (int j = 0; j < PC_W; j++) begin
      f_ch_idx[j % CH_IDX_W] ^= fetch_pc_i[j];
      u_ch_idx[j % CH_IDX_W] ^= upd_pc_i[j];
      f_dpc[j % DIR_IDX_W]   ^= fetch_pc_i[j];
      u_dpc[j % DIR_IDX_W]   ^= upd_pc_i[j];
    end
    for (int j = 0; j < GHR_W; j++) begin
      f_hist[j % DIR_IDX_W] ^= ghr_q[j];
      u_hist[j % DIR_IDX_W] ^= upd_ghr_i[j];
    end
  end

  assign f_dir_idx = f_dpc ^ f_hist;
  assign u_dir_idx = u_dpc ^ u_hist;

  logic f_ch_pred, u_ch_pred;
  logic f_t_pred, u_t_pred, f_n_pred, u_n_pred;
  logic ch_we, t_we, n_we, sel_pred;

  bimode_ctr_table #(.IDX_W(CH_IDX_W), .RST_VAL(CTR_WEAK_NT)) u_choice (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fetch_idx_i  (f_ch_idx),
    .fetch_pred_o (f_ch_pred),
    .upd_idx_i    (u_ch_idx),
    .upd_pred_o   (u_ch_pred),
    .upd_en_i     (ch_we),
    .upd_taken_i  (upd_taken_i)
  );

  bimode_ctr_table #(.IDX_W(DIR_IDX_W), .RST_VAL(CTR_WEAK_T)) u_tbl_t (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fetch_idx_i  (f_dir_idx),
    .fetch_pred_o (f_t_pred),
    .upd_idx_i    (u_dir_idx),
    .upd_pred_o   (u_t_pred),
    .upd_en_i     (t_we),
    .upd_taken_i  (upd_taken_i)
  );

  bimode_ctr_table #(.IDX_W(DIR_IDX_W), .RST_VAL(CTR_WEAK_NT)) u_tbl_n (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fetch_idx_i  (f_dir_idx),
    .fetch_pred_o (f_n_pred),
    .upd_idx_i    (u_dir_idx),
    .upd_pred_o   (u_n_pred),
    .upd_en_i     (n_we),
    .upd_taken_i  (upd_taken_i)
  );

  bimode_ghr #(.W(GHR_W)) u_ghr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (upd_valid_i),
    .bit_i   (upd_taken_i),
    .ghr_o   (ghr_q)
  );

  // Training: chosen direction table always; choice unless it was wrong but rescued
  always_comb begin
    sel_pred = u_ch_pred ? u_t_pred : u_n_pred;
    t_we     = upd_valid_i &  u_ch_pred;
    n_we     = upd_valid_i & ~u_ch_pred;
    ch_we    = upd_valid_i & ~((u_ch_pred != upd_taken_i) && (sel_pred == upd_taken_i));
  end

  assign pred_taken_o = f_ch_pred ? f_t_pred : f_n_pred;
  assign ghr_o        = ghr_q;
endmodule

// File: rtl/bimode_pred_chk.sv
module bimode_pred_chk #(
  parameter int GHR_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             upd_valid_i,
  input logic             upd_taken_i,
  input logic [GHR_W-1:0] ghr_o,
  input logic             ch_pred_i,
  input logic             sel_pred_i,
  input logic             ch_we_i,
  input logic             t_we_i,
  input logic             n_we_i
);
  // R8
  ghr_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=> ghr_o == {$past(ghr_o[GHR_W-2:0]), $past(upd_taken_i)});

  // R8
  ghr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> $stable(ghr_o));

  // R5
  one_dir_trained_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |-> $onehot({t_we_i, n_we_i}));

  // R5
  idle_no_train_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |-> !(t_we_i || n_we_i || ch_we_i));

  // R6
  choice_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && ch_pred_i != upd_taken_i && sel_pred_i == upd_taken_i) |-> !ch_we_i);

  // R6
  choice_agree_train_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && ch_pred_i == upd_taken_i) |-> ch_we_i);
endmodule

bind bimode_pred bimode_pred_chk #(.GHR_W(GHR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .upd_valid_i (upd_valid_i),
  .upd_taken_i (upd_taken_i),
  .ghr_o       (ghr_o),
  .ch_pred_i   (u_ch_pred),
  .sel_pred_i  (sel_pred),
  .ch_we_i     (ch_we),
  .t_we_i      (t_we),
  .n_we_i      (n_we)
);

// File: tb/bimode_pred_tb.sv
module bimode_pred_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 12;
  localparam int GW   = 8;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic [PC_W-1:0] fetch_pc = '0;
  logic            pred_taken;
  logic            upd_valid = 1'b0;
  logic [PC_W-1:0] upd_pc = '0;
  logic            upd_taken = 1'b0;
  logic [GW-1:0]   upd_ghr = '0;
  logic [GW-1:0]   ghr;

  int checks = 0;
  int errors = 0;

  // model state, derived from the requirements
  int            m_ch [256];
  int            m_t  [256];
  int            m_n  [256];
  logic [GW-1:0] m_ghr;

  always #(CLK_PERIOD/2) clk = ~clk;

  bimode_pred u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .fetch_pc_i   (fetch_pc),
    .pred_taken_o (pred_taken),
    .upd_valid_i  (upd_valid),
    .upd_pc_i     (upd_pc),
    .upd_taken_i  (upd_taken),
    .upd_ghr_i    (upd_ghr),
    .ghr_o        (ghr)
  );

  function automatic logic [7:0] fold(logic [PC_W-1:0] pc);
    return pc[7:0] ^ {4'b0, pc[11:8]};
  endfunction

  function automatic int sat(int c, logic t);
    if (t) return (c == 3) ? 3 : c + 1;
    else   return (c == 0) ? 0 : c - 1;
  endfunction

  function automatic logic m_pred(logic [PC_W-1:0] pc);
    logic [7:0] d;
    d = fold(pc) ^ m_ghr;
    return (m_ch[fold(pc)] >= 2) ? (m_t[d] >= 2) : (m_n[d] >= 2);
  endfunction

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    upd_valid = 1'b0;
    for (int i = 0; i < 256; i++) begin
      m_ch[i] = 1; m_t[i] = 2; m_n[i] = 1;
    end
    m_ghr = '0;
    #(2*CLK_PERIOD);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic upd(logic [PC_W-1:0] pc, logic t, logic [GW-1:0] g);
    logic [7:0] c, d;
    logic sel, sp;
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_taken = t; upd_ghr = g;
    @(negedge clk);
    upd_valid = 1'b0;
    c = fold(pc); d = fold(pc) ^ g;
    sel = m_ch[c] >= 2;
    sp  = sel ? (m_t[d] >= 2) : (m_n[d] >= 2);
    if (sel) m_t[d] = sat(m_t[d], t);
    else     m_n[d] = sat(m_n[d], t);
    if (!((sel != t) && (sp == t))) m_ch[c] = sat(m_ch[c], t);
    m_ghr = {m_ghr[GW-2:0], t};
  endtask

  task automatic pred_chk(logic [PC_W-1:0] pc, string req);
    fetch_pc = pc;
    #1;
    check(req, pred_taken, m_pred(pc), "prediction vs model");
  endtask

  // R1: reset state
  task automatic t_reset();
    do_reset();
    #1;
    check("R1", ghr, 0, "history after reset");
    for (int k = 0; k < 4; k++) begin
      fetch_pc = PC_W'(k * 293 + 7);
      #1;
      check("R1", pred_taken, 0, "prediction after reset");
    end
  endtask

  // R8: history shift
  task automatic t_ghr();
    do_reset();
    upd(12'h111, 1'b1, ghr);
    upd(12'h222, 1'b0, ghr);
    upd(12'h333, 1'b1, ghr);
    upd(12'h444, 1'b1, ghr);
    #1;
    check("R8", ghr, 8'b0000_1011, "history after T,N,T,T");
    repeat (3) @(negedge clk);
    #1;
    check("R8", ghr, 8'b0000_1011, "history held while idle");
  endtask

  // R6, R5, R4: choice left unchanged when rescued by direction table
  task automatic t_choice_skip();
    do_reset();
    upd(12'h010, 1'b1, 8'h00);  // choice[10] -> 10, nt[10] -> 10
    upd(12'h020, 1'b1, 8'h30);  // dir idx 10: nt predicts T, choice[20] stays 01
    // current history 03: pc 020 -> dir 23 (fresh), choice[20] must still pick nt table
    fetch_pc = 12'h020; #1;
    check("R6", pred_taken, 0, "choice kept not-taken after rescue");
    // pc 013: choice fresh, dir idx 10 -> nt table trained to 11
    fetch_pc = 12'h013; #1;
    check("R5", pred_taken, 1, "selected nt table trained");
    pred_chk(12'h010, "R4");
    pred_chk(12'h020, "R6");
  endtask

  // R7, R9: saturation read back through fixed saved history
  task automatic t_saturate();
    do_reset();
    for (int k = 0; k < 4; k++) upd(12'h040, 1'b1, 8'h1E);
    upd(12'h040, 1'b0, 8'h1E);
    #1;
    check("R9", ghr, 8'h1E, "history after training");
    fetch_pc = 12'h040; #1;
    check("R7", pred_taken, 1, "saturated counter still taken after one miss");
    pred_chk(12'h040, "R7");
  endtask

  // R2, R3, R4, R9: long mixed stream against model
  task automatic t_stream();
    logic [GW-1:0] prev;
    logic [15:0]   lfsr;
    logic [PC_W-1:0] pcs [6];
    do_reset();
    pcs[0] = 12'h0A4; pcs[1] = 12'h3F0; pcs[2] = 12'h5A5;
    pcs[3] = 12'h0A5; pcs[4] = 12'h7C1; pcs[5] = 12'hC12;
    lfsr = 16'hACE1;
    prev = '0;
    for (int n = 0; n < 900; n++) begin
      int s;
      logic t;
      logic [GW-1:0] g;
      s = n % 6;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (s)
        0: t = (n % 48) != 0;
        1: t = n[1];
        2: t = lfsr[0];
        3: t = 1'b0;
        4: t = lfsr[3] | lfsr[5];
        default: t = (n % 5) < 2;
      endcase
      pred_chk(pcs[s], (s % 2 == 0) ? "R2" : "R3");
      #1;
      check("R8", ghr, m_ghr, "history vs model");
      g = (n % 3 == 2) ? prev : ghr;
      prev = ghr;
      upd(pcs[s], t, g);
    end
    for (int k = 0; k < 6; k++) pred_chk(pcs[k], "R9");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_ghr();
    t_choice_skip();
    t_saturate();
    t_stream();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule